// File: doc/BRIEF.md
# Partition Freeze State Table

This block keeps the error-isolation state of every partition behind one host bridge. Each partition owns two freeze flags: one gates outbound memory-mapped traffic, the other gates inbound traffic (device reads and writes of memory, and message-signalled interrupts). A single freeze event raises both flags of a partition at once. Software then lowers each flag through its own clear port, so that, for example, memory-mapped access can be restored for diagnosis while inbound traffic stays fenced.

A query port takes a partition number and a transaction kind and reports at once whether that transaction must be suppressed. A frozen store or write is dropped, a frozen load has its read data replaced by all ones, and a frozen interrupt is blocked. A companion table holds, for each partition, a bitmap of other partitions. When a freeze is triggered by an inbound error message, every partition named in that bitmap is frozen in the same cycle. Freezes from any other cause stay confined to the one partition.

All ports are plain level signals sampled on the rising clock edge. The block has no handshake: every event and clear presented with its valid bit is taken in that cycle, and query outputs are pure functions of the inputs and the stored state.

Top module: `part_freeze_table`

## Requirements
- R1: Reset lowers both freeze flags of every partition and empties every companion bitmap, so a cascading freeze taken straight after reset freezes only its own partition.
- R2: A freeze event (frz_valid high) raises both the MMIO flag and the DMA flag of partition frz_pid; the query outputs show it from the cycle after the event.
- R3: clr_mmio_valid lowers only the MMIO flag of clr_mmio_pid and clr_dma_valid lowers only the DMA flag of clr_dma_pid; the other flag and all other partitions keep their state.
- R4: When a freeze (direct or cascaded) and a clear reach the same flag in the same cycle, the flag ends up raised.
- R5: Transaction kinds are coded on q_kind as 0 MMIO load, 1 MMIO store, 2 DMA read, 3 DMA write, 4 MSI; codes 5 to 7 are never suppressed. Kinds 0 and 1 follow the MMIO flag of q_pid, kinds 2 to 4 follow its DMA flag, and q_block is high exactly when the governing flag is raised.
- R6: For a load kind (0 or 2) whose governing flag is raised, q_rdata is all ones; in every other case q_rdata equals q_rdata_in.
- R7: An MSI query (kind 4) of a partition whose DMA flag is raised reports q_block high; the MMIO flag alone does not block it.
- R8: A freeze with frz_err_msg high also raises both flags of every partition whose bit is set in the companion bitmap of frz_pid; with frz_err_msg low no other partition changes.
- R9: A companion write (cmp_wr_valid) replaces the whole bitmap of cmp_wr_pid from the next cycle on; a cascading freeze in the same cycle as a write to its own partition uses the bitmap held before the write.
- R10: With no freeze and no clear presented, no freeze flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| frz_valid | input | 1 | Freeze event for frz_pid this cycle |
| frz_pid | input | PW | Partition to freeze |
| frz_err_msg | input | 1 | Event comes from an inbound error message; enables cascading |
| clr_mmio_valid | input | 1 | Clear the MMIO flag of clr_mmio_pid |
| clr_mmio_pid | input | PW | Partition whose MMIO flag is cleared |
| clr_dma_valid | input | 1 | Clear the DMA flag of clr_dma_pid |
| clr_dma_pid | input | PW | Partition whose DMA flag is cleared |
| cmp_wr_valid | input | 1 | Write a companion bitmap |
| cmp_wr_pid | input | PW | Partition whose bitmap is written |
| cmp_wr_map | input | NUM_PART | New companion bitmap, bit j names partition j |
| q_pid | input | PW | Partition of the queried transaction |
| q_kind | input | 3 | Transaction kind code |
| q_rdata_in | input | DATA_W | Read data returned for the transaction |
| q_block | output | 1 | Transaction must be suppressed |
| q_rdata | output | DATA_W | Read data after all-ones substitution |

## Verification
Every freeze, clear and companion write is due one rising edge after it is presented, while every query result is due in the same cycle as its inputs, without any register on the way. The bench therefore drives an operation on a falling edge, lets exactly one rising edge pass, removes the operation on the following falling edge and only then sweeps every partition against every kind code, waiting a short settle time after each query change. Because the inputs are idle during the sweep, the rising edges it spans also confirm that flags hold still when nothing is presented.

// File: rtl/pft_pkg.sv
`timescale 1ns/1ps
package pft_pkg;
  typedef enum logic [2:0] {
    TK_MMIO_LD = 3'd0,
    TK_MMIO_ST = 3'd1,
    TK_DMA_RD  = 3'd2,
    TK_DMA_WR  = 3'd3,
    TK_MSI     = 3'd4
  } txn_kind_e;

  localparam int CLS_MMIO = 0;
  localparam int CLS_DMA  = 1;
  localparam int NUM_CLS  = 2;
endpackage

// File: rtl/pft_flag_vec.sv
`timescale 1ns/1ps
// One freeze flag per partition for a single traffic class.
module pft_flag_vec #(
  parameter int N  = 256,
  parameter int PW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  set_vec,
  input  logic          clr_en,
  input  logic [PW-1:0] clr_pid,
  output logic [N-1:0]  flags
);
  logic [N-1:0] clr_vec;

  always_comb begin
    clr_vec = '0;
    if (clr_en) clr_vec = {{(N-1){1'b0}}, 1'b1} << clr_pid;
  end

  // set is applied after clear so it wins on a collision
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_vec) | set_vec;
  end
endmodule

// File: rtl/pft_comp_table.sv
`timescale 1ns/1ps
// Per-partition bitmap of partitions that share a cascading freeze.
module pft_comp_table #(
  parameter int N  = 256,
  parameter int PW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_pid,
  input  logic [N-1:0]  wr_map,
  input  logic [PW-1:0] rd_pid,
  output logic [N-1:0]  rd_map
);
  logic [N-1:0] map_q [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) map_q[i] <= '0;
    end else if (wr_en) begin
      map_q[wr_pid] <= wr_map;
    end
  end

  assign rd_map = map_q[rd_pid];
endmodule

// File: rtl/pft_query.sv
`timescale 1ns/1ps
// Combinational suppression decision and read-data substitution.
module pft_query
  import pft_pkg::*;
#(
  parameter int N      = 256,
  parameter int PW     = $clog2(N),
  parameter int DATA_W = 64
) (
  input  logic [N-1:0]      mmio_flags,
  input  logic [N-1:0]      dma_flags,
  input  logic [PW-1:0]     q_pid,
  input  logic [2:0]        q_kind,
  input  logic [DATA_W-1:0] q_rdata_in,
  output logic              q_block,
  output logic [DATA_W-1:0] q_rdata
);
  logic is_load;

  always_comb begin
    q_block = 1'b0;
    is_load = 1'b0;
    case (q_kind)
      TK_MMIO_LD: begin q_block = mmio_flags[q_pid]; is_load = 1'b1; end
      TK_MMIO_ST: q_block = mmio_flags[q_pid];
      TK_DMA_RD:  begin q_block = dma_flags[q_pid]; is_load = 1'b1; end
      TK_DMA_WR:  q_block = dma_flags[q_pid];
      TK_MSI:     q_block = dma_flags[q_pid];
      default:    q_block = 1'b0;
    endcase
    q_rdata = (q_block && is_load) ? {DATA_W{1'b1}} : q_rdata_in;
  end
endmodule

// File: rtl/part_freeze_table.sv
`timescale 1ns/1ps
module part_freeze_table
  import pft_pkg::*;
#(
  parameter  int NUM_PART = 256,
  parameter  int DATA_W   = 64,
  localparam int PW       = $clog2(NUM_PART)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frz_valid,
  input  logic [PW-1:0]       frz_pid,
  input  logic                frz_err_msg,
  input  logic                clr_mmio_valid,
  input  logic [PW-1:0]       clr_mmio_pid,
  input  logic                clr_dma_valid,
  input  logic [PW-1:0]       clr_dma_pid,
  input  logic                cmp_wr_valid,
  input  logic [PW-1:0]       cmp_wr_pid,
  input  logic [NUM_PART-1:0] cmp_wr_map,
  input  logic [PW-1:0]       q_pid,
  input  logic [2:0]          q_kind,
  input  logic [DATA_W-1:0]   q_rdata_in,
  output logic                q_block,
  output logic [DATA_W-1:0]   q_rdata
);
  logic [NUM_PART-1:0] cmp_map;
  logic [NUM_PART-1:0] set_vec;
  logic [NUM_PART-1:0] mmio_frz;
  logic [NUM_PART-1:0] dma_frz;
  logic [NUM_PART-1:0] flags_v  [NUM_CLS];
  logic                clr_en_v [NUM_CLS];
  logic [PW-1:0]       clr_pid_v[NUM_CLS];

  pft_comp_table #(.N(NUM_PART), .PW(PW)) i_comp (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cmp_wr_valid),
    .wr_pid (cmp_wr_pid),
    .wr_map (cmp_wr_map),
    .rd_pid (frz_pid),
    .rd_map (cmp_map)
  );

  // both classes receive the same set vector: flags rise together
  always_comb begin
    set_vec = '0;
    if (frz_valid) begin
      set_vec = {{(NUM_PART-1){1'b0}}, 1'b1} << frz_pid;
      if (frz_err_msg) set_vec = set_vec | cmp_map;
    end
  end

  assign clr_en_v[CLS_MMIO]  = clr_mmio_valid;
  assign clr_pid_v[CLS_MMIO] = clr_mmio_pid;
  assign clr_en_v[CLS_DMA]   = clr_dma_valid;
  assign clr_pid_v[CLS_DMA]  = clr_dma_pid;

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    pft_flag_vec #(.N(NUM_PART), .PW(PW)) i_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (set_vec),
      .clr_en  (clr_en_v[c]),
      .clr_pid (clr_pid_v[c]),
      .flags   (flags_v[c])
    );
  end

  assign mmio_frz = flags_v[CLS_MMIO];
  assign dma_frz  = flags_v[CLS_DMA];

  pft_query #(.N(NUM_PART), .PW(PW), .DATA_W(DATA_W)) i_query (
    .mmio_flags (mmio_frz),
    .dma_flags  (dma_frz),
    .q_pid      (q_pid),
    .q_kind     (q_kind),
    .q_rdata_in (q_rdata_in),
    .q_block    (q_block),
    .q_rdata    (q_rdata)
  );
endmodule

// File: rtl/part_freeze_table_chk.sv
`timescale 1ns/1ps
module part_freeze_table_chk #(
  parameter int N      = 256,
  parameter int PW     = $clog2(N),
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frz_valid,
  input logic [PW-1:0]     frz_pid,
  input logic              frz_err_msg,
  input logic              clr_mmio_valid,
  input logic [PW-1:0]     clr_mmio_pid,
  input logic              clr_dma_valid,
  input logic [PW-1:0]     clr_dma_pid,
  input logic [N-1:0]      cmp_map,
  input logic [N-1:0]      mmio_frz,
  input logic [N-1:0]      dma_frz,
  input logic [PW-1:0]     q_pid,
  input logic [2:0]        q_kind,
  input logic [DATA_W-1:0] q_rdata_in,
  input logic              q_block,
  input logic [DATA_W-1:0] q_rdata
);
  AST_FREEZE_SETS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    frz_valid |=> (mmio_frz[$past(frz_pid)] && dma_frz[$past(frz_pid)])); // R2

  AST_CLR_MMIO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mmio_valid && !clr_dma_valid && !frz_valid) |=>
      (!mmio_frz[$past(clr_mmio_pid)] &&
       dma_frz[$past(clr_mmio_pid)] == $past(dma_frz[clr_mmio_pid]))); // R3

  AST_CLR_DMA_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_dma_valid && !frz_valid) |=> !dma_frz[$past(clr_dma_pid)]); // R3

  AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_valid && clr_mmio_valid && clr_mmio_pid == frz_pid) |=>
      mmio_frz[$past(frz_pid)]); // R4

  AST_STORE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (q_kind == 3'd1 && mmio_frz[q_pid]) |-> q_block); // R5

  AST_LOAD_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (q_kind == 3'd0 && mmio_frz[q_pid]) |-> (q_rdata == {DATA_W{1'b1}})); // R6

  AST_PASS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (!mmio_frz[q_pid] && !dma_frz[q_pid]) |-> (!q_block && q_rdata == q_rdata_in)); // R6

  AST_MSI_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (q_kind == 3'd4 && dma_frz[q_pid]) |-> q_block); // R7

  AST_CASCADE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_valid && frz_err_msg) |=>
      ((mmio_frz & $past(cmp_map)) == $past(cmp_map) &&
       (dma_frz & $past(cmp_map)) == $past(cmp_map))); // R8

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!frz_valid && !clr_mmio_valid && !clr_dma_valid) |=>
      ($stable(mmio_frz) && $stable(dma_frz))); // R10
endmodule

bind part_freeze_table part_freeze_table_chk #(.N(NUM_PART), .PW(PW), .DATA_W(DATA_W)) i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .frz_valid      (frz_valid),
  .frz_pid        (frz_pid),
  .frz_err_msg    (frz_err_msg),
  .clr_mmio_valid (clr_mmio_valid),
  .clr_mmio_pid   (clr_mmio_pid),
  .clr_dma_valid  (clr_dma_valid),
  .clr_dma_pid    (clr_dma_pid),
  .cmp_map        (cmp_map),
  .mmio_frz       (mmio_frz),
  .dma_frz        (dma_frz),
  .q_pid          (q_pid),
  .q_kind         (q_kind),
  .q_rdata_in     (q_rdata_in),
  .q_block        (q_block),
  .q_rdata        (q_rdata)
);

// File: tb/test_part_freeze_table.sv
`timescale 1ns/1ps
module test_part_freeze_table;
  localparam int NP = 8;
  localparam int PW = 3;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frz_valid = 0, frz_err_msg = 0;
  logic [PW-1:0] frz_pid = '0;
  logic          clr_mmio_valid = 0, clr_dma_valid = 0, cmp_wr_valid = 0;
  logic [PW-1:0] clr_mmio_pid = '0, clr_dma_pid = '0, cmp_wr_pid = '0;
  logic [NP-1:0] cmp_wr_map = '0;
  logic [PW-1:0] q_pid = '0;
  logic [2:0]    q_kind = '0;
  logic [DW-1:0] q_rdata_in = '0;
  logic          q_block;
  logic [DW-1:0] q_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [NP-1:0] m_mdl = '0, d_mdl = '0;
  logic [NP-1:0] c_mdl [NP];

  always #10 clk = ~clk;

  part_freeze_table #(.NUM_PART(NP), .DATA_W(DW)) i_part_freeze_table (
    .clk(clk), .rst_n(rst_n),
    .frz_valid(frz_valid), .frz_pid(frz_pid), .frz_err_msg(frz_err_msg),
    .clr_mmio_valid(clr_mmio_valid), .clr_mmio_pid(clr_mmio_pid),
    .clr_dma_valid(clr_dma_valid), .clr_dma_pid(clr_dma_pid),
    .cmp_wr_valid(cmp_wr_valid), .cmp_wr_pid(cmp_wr_pid), .cmp_wr_map(cmp_wr_map),
    .q_pid(q_pid), .q_kind(q_kind), .q_rdata_in(q_rdata_in),
    .q_block(q_block), .q_rdata(q_rdata)
  );

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // Query every partition with every kind code and compare to the model.
  task automatic sweep(input string tag);
    for (int p = 0; p < NP; p++) begin
      for (int k = 0; k < 8; k++) begin
        logic [DW-1:0] rin, exp_d;
        logic exp_b;
        string rq;
        rin = DW'(p * 37 + k * 11 + 5);
        q_pid = PW'(p); q_kind = 3'(k); q_rdata_in = rin;
        #1;
        exp_b = (k < 2) ? m_mdl[p] : ((k < 5) ? d_mdl[p] : 1'b0);
        exp_d = (exp_b && (k == 0 || k == 2)) ? {DW{1'b1}} : rin;
        rq = (k == 4) ? "R7" : ((k == 0 || k == 2) ? "R6" : "R5");
        checks++;
        if (q_block !== exp_b || q_rdata !== exp_d) begin
          fails++;
          $display("FAIL %s/%s pid=%0d kind=%0d block=%b exp=%b rdata=%h exp=%h",
                   tag, rq, p, k, q_block, exp_b, q_rdata, exp_d);
        end
      end
    end
  endtask

  task automatic apply(input logic fv, input int fp, input logic fe,
                       input logic cmv, input int cmp, input logic cdv, input int cdp,
                       input logic cwv, input int cwp, input logic [NP-1:0] cwm,
                       input string tag);
    logic [NP-1:0] setv;
    @(negedge clk);
    frz_valid = fv; frz_pid = PW'(fp); frz_err_msg = fe;
    clr_mmio_valid = cmv; clr_mmio_pid = PW'(cmp);
    clr_dma_valid = cdv; clr_dma_pid = PW'(cdp);
    cmp_wr_valid = cwv; cmp_wr_pid = PW'(cwp); cmp_wr_map = cwm;
    setv = '0;
    if (fv) begin
      setv[fp] = 1'b1;
      if (fe) setv = setv | c_mdl[fp];
    end
    if (cmv) m_mdl[cmp] = 1'b0;
    if (cdv) d_mdl[cdp] = 1'b0;
    m_mdl = m_mdl | setv;
    d_mdl = d_mdl | setv;
    if (cwv) c_mdl[cwp] = cwm;
    @(negedge clk);
    frz_valid = 0; frz_err_msg = 0; clr_mmio_valid = 0; clr_dma_valid = 0; cmp_wr_valid = 0;
    sweep(tag);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NP; i++) c_mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    sweep("R1");
    // R1: companion maps empty after reset -> cascade stays local; R2 both flags
    apply(1, 3, 1, 0, 0, 0, 0, 0, 0, '0, "R1_R2");
    // R3: clear each class separately
    apply(0, 0, 0, 1, 3, 0, 0, 0, 0, '0, "R3");
    apply(0, 0, 0, 0, 0, 1, 3, 0, 0, '0, "R3");
    // R9/R8: write map then cascade from an error message
    apply(0, 0, 0, 0, 0, 0, 0, 1, 2, 8'b1010_0001, "R9");
    apply(1, 2, 1, 0, 0, 0, 0, 0, 0, '0, "R8");
    for (int i = 0; i < NP; i++) apply(0, 0, 0, 1, i, 1, i, 0, 0, '0, "R3");
    // R8: non-message cause does not cascade
    apply(1, 2, 0, 0, 0, 0, 0, 0, 0, '0, "R8");
    // R4: direct and cascaded set beat same-cycle clears
    apply(1, 4, 0, 1, 4, 1, 4, 0, 0, '0, "R4");
    apply(1, 2, 1, 1, 0, 1, 7, 0, 0, '0, "R4");
    for (int i = 0; i < NP; i++) apply(0, 0, 0, 1, i, 1, i, 0, 0, '0, "R3");
    // R9: same-cycle write to the freezing partition uses the old map
    apply(1, 2, 1, 0, 0, 0, 0, 1, 2, 8'b0001_0010, "R9");
    apply(1, 2, 1, 0, 0, 0, 0, 0, 0, '0, "R9");
    // R10: idle cycles leave flags unchanged
    repeat (5) @(negedge clk);
    sweep("R10");
    // mixed sequence against the model
    for (int n = 0; n < 300; n++) begin
      logic [31:0] r;
      r = $urandom;
      apply(r[0] & r[1], int'(r[4:2]), r[5], r[6], int'(r[9:7]), r[10], int'(r[13:11]),
            r[14] & r[15], int'(r[18:16]), r[26:19], "R8_R9");
    end
    done = 1;
    summary();
    $finish;
  end
endmodule